// File: doc/BRIEF.md
# SPI Command Bridge to a Word Bus

This block is an SPI slave that lets an external host reach an internal 32-bit memory bus. Every SPI transaction, framed by chip select, begins with a one-byte opcode. Some opcodes carry a four-byte big-endian payload. Others start an open-ended byte stream into or out of the block. The rest act at once. Host write data is packed into 32-bit words and queued in a write FIFO. Bus read data is queued in a read FIFO, and the host streams it out.

A bus engine sits behind the FIFOs and uses a request/acknowledge handshake. It drains the write FIFO whenever the FIFO holds a word. It fetches the number of words that the host asked for, starting at the current bus address, and it waits while the read FIFO is full. The host learns the fill level of both FIFOs from a packed status word, so it can pace its streams. The host can also clear either FIFO, switch address auto-increment on or off, raise a flag that locks out other bus users, and send a reset pulse to the downstream target.

Top module: `spi_bus_bridge`

## Requirements
- R1: After reset, opcode 0x00 returns four bytes, most significant first, and the status word reads {STATUS_ID[7:0], incr=1, lock=0, write count[21:11]=0, read count[10:0]=0}. `bus_req` and `ext_access_off` are low.
- R2: Opcode 0x10 takes a 32-bit big-endian payload. Payload bit 0 drives `ext_access_off` and status bit 22. Payload bit 1 sets auto-increment and status bit 23.
- R3: Opcode 0x40 streams bytes. Each group of four bytes forms one word, first byte in bits [31:24], and the block writes it on the bus. With auto-increment on, successive words go to byte addresses that rise by 4, starting at the address that opcode 0x20 loaded.
- R4: With auto-increment off, every bus transfer uses the same address.
- R5: Opcode 0x30 with payload N starts N+1 bus reads from the current address into the read FIFO. Opcode 0x50 then streams the FIFO words out, first byte holding bits [31:24].
- R6: Fetching pauses while the read FIFO is full and resumes when the host drains it. The total number of reads stays N+1.
- R7: Opcode 0xFE empties the read FIFO and cancels any reads not yet issued.
- R8: Opcode 0xFD empties the write FIFO. A word already on the bus still completes.
- R9: A word that completes while the write FIFO is full is dropped, and neither FIFO count ever exceeds its depth.
- R10: When chip select goes high in the middle of a payload, the payload is discarded, and the first byte of the next transaction is an opcode.
- R11: Opcode 0xFF is a single byte. The byte after it is decoded as a new opcode.
- R12: Opcode 0xFC followed by four bytes produces exactly one one-cycle pulse on `tgt_reset`.
- R13: A pending write is issued before a pending read. Once raised, `bus_req` stays high, with address, direction and data held, until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host to block data, MSB first |
| spi_miso | output | 1 | Block to host data, MSB first |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the transfer |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer done; read data valid this cycle |
| bus_rdata | input | 32 | Read data |
| ext_access_off | output | 1 | Lock-out flag for other bus users |
| tgt_reset | output | 1 | One-cycle reset pulse to the target |

## Verification
The bench builds the bridge with FIFO_DEPTH=8 and keeps STATUS_ID at its default. With that depth, a twelve-word fetch runs the read FIFO full and shows the engine stalling and then resuming. A burst of ten words against a stalled bus overflows the write FIFO. Both cases use only a few SPI bytes. The bus target is a 64-word RAM whose acknowledge the bench can withhold. This lets it hold a transfer in flight while it flushes a FIFO or queues a read behind writes, and then check the order of the bus operations.

// File: rtl/sbb_pkg.sv
// Shared opcode definitions for the SPI command bridge.
package sbb_pkg;
    typedef enum logic [7:0] {
        OP_STATUS = 8'h00,
        OP_CONFIG = 8'h10,
        OP_ADDR   = 8'h20,
        OP_RDLEN  = 8'h30,
        OP_WRITE  = 8'h40,
        OP_READ   = 8'h50,
        OP_TRST   = 8'hFC,
        OP_FLUSHW = 8'hFD,
        OP_FLUSHR = 8'hFE,
        OP_IDLE   = 8'hFF
    } opcode_t;
endpackage

// File: rtl/sbb_spi_shift.sv
// SPI mode-0 byte shifter. Synchronises the SPI pins to clk, samples MOSI on
// rising SCLK and shifts MISO on falling SCLK. Assumes SCLK is at least
// four times slower than clk. tx_byte must be valid before the falling edge
// that follows rx_valid.
module sbb_spi_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       sel,
    output logic       miso
);
    logic [2:0] s_sclk;
    logic [1:0] s_cs;
    logic [1:0] s_mosi;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rise, fall;

    // Two-stage synchronisers plus an edge-detect stage for SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sclk <= '0;
            s_cs   <= 2'b11;
            s_mosi <= '0;
        end else begin
            s_sclk <= {s_sclk[1:0], sclk_i};
            s_cs   <= {s_cs[0], cs_n_i};
            s_mosi <= {s_mosi[0], mosi_i};
        end
    end

    assign rise = s_sclk[1] & ~s_sclk[2];
    assign fall = ~s_sclk[1] & s_sclk[2];
    assign sel  = ~s_cs[1];
    assign miso = tx_sr[7];

    // Bit counting, receive assembly and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sr   <= {rx_sr[5:0], s_mosi[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr, s_mosi[1]};
                end
            end
            if (fall) begin
                tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sbb_fifo.sv
// Synchronous single-clock FIFO with a combinational head and a flush.
// Assumes DEPTH is a power of two. A push when full and a pop when empty
// are ignored, and flush takes priority over both.
module sbb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R9: occupancy never exceeds depth, and no push arrives at a full FIFO unless flushed.
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush && !pop |=> count == CW'(DEPTH));
endmodule

// File: rtl/sbb_bus_engine.sv
// Bus master between the FIFOs and a request/acknowledge word bus. It pops a
// write word at issue and pushes a read word at acknowledge, with at most one
// transfer in flight. Writes win over reads. Assumes bus_ack only comes while
// bus_req is high.
module sbb_bus_engine #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 32,
    localparam int RW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          incr,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_val,
    input  logic          len_load,
    input  logic [LW-1:0] len_val,
    input  logic          flush_rd,
    input  logic          wf_empty,
    input  logic [DW-1:0] wf_head,
    output logic          wf_pop,
    input  logic          rf_full,
    output logic          rf_push,
    output logic [DW-1:0] rf_din,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    logic [RW-1:0] rd_left;
    logic          stale;
    logic          issue_wr, issue_rd, done;

    assign issue_wr = ~bus_req & ~wf_empty;
    assign issue_rd = ~bus_req & wf_empty & (rd_left != '0) & ~rf_full & ~len_load & ~flush_rd;
    assign done     = bus_req & bus_ack;
    assign wf_pop   = issue_wr;
    assign rf_push  = done & ~bus_we & ~stale;
    assign rf_din   = bus_rdata;

    // Transfer issue, completion and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            if (issue_wr) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_wdata <= wf_head;
            end else if (issue_rd) begin
                bus_req <= 1'b1;
                bus_we  <= 1'b0;
            end else if (done) begin
                bus_req <= 1'b0;
            end
            if (addr_load && !bus_req)
                bus_addr <= addr_val;
            else if (addr_load && done)
                bus_addr <= addr_val;
            else if (done && incr)
                bus_addr <= bus_addr + AW'(4);
        end
    end

    // Remaining-read counter and the drop flag for a read flushed in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_left <= '0;
            stale   <= 1'b0;
        end else begin
            if (flush_rd)      rd_left <= '0;
            else if (len_load) rd_left <= RW'(len_val) + RW'(1);
            else if (issue_rd) rd_left <= rd_left - RW'(1);
            if (flush_rd && bus_req && !bus_we && !done) stale <= 1'b1;
            else if (done)                               stale <= 1'b0;
        end
    end

    // R13: a raised request holds address, direction and data until acknowledged.
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_wdata));
    // R13: a read is only started when no write word was waiting.
    p_write_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && !bus_we |-> $past(wf_empty));
    // R6: a read in flight always has room in the read FIFO.
    p_read_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && !stale |-> !rf_full);
endmodule

// File: rtl/spi_bus_bridge.sv
// Top of the SPI command bridge. Holds the opcode parser, the config and
// address commit logic, the status word and both FIFOs. Bytes reach the
// parser from sbb_spi_shift, and bus traffic goes through sbb_bus_engine.
// Assumes FIFO_DEPTH is a power of two no larger than 1024, so each count
// fits its 11-bit status field.
module spi_bus_bridge #(
    parameter int         FIFO_DEPTH = 1024,
    parameter logic [7:0] STATUS_ID  = 8'h5C,
    localparam int        CW         = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        ext_access_off,
    output logic        tgt_reset
);
    import sbb_pkg::*;

    logic [7:0]    rx_byte, tx_byte;
    logic          rx_valid, sel;
    logic          in_cmd;
    opcode_t       op;
    logic [1:0]    idx;
    logic [23:0]   pl;
    logic [31:0]   word, stat_q, status_now;
    logic          incr_q;
    logic          last;
    logic          wf_push, wf_pop, wf_full, wf_empty, wf_flush;
    logic          rf_push, rf_pop, rf_full, rf_empty, rf_flush;
    logic [31:0]   wf_head, rf_head, rf_din;
    logic [CW-1:0] wf_count, rf_count;
    logic          addr_load, len_load;

    sbb_spi_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .sel(sel), .miso(spi_miso)
    );

    assign word       = {pl, rx_byte};
    assign last       = rx_valid & in_cmd & (idx == 2'd3);
    assign status_now = {STATUS_ID, incr_q, ext_access_off,
                         11'(wf_count), 11'(rf_count)};
    assign wf_push    = last & (op == OP_WRITE) & ~wf_full;
    assign rf_pop     = last & (op == OP_READ);
    assign addr_load  = last & (op == OP_ADDR);
    assign len_load   = last & (op == OP_RDLEN);
    assign wf_flush   = rx_valid & ~in_cmd & (rx_byte == OP_FLUSHW);
    assign rf_flush   = rx_valid & ~in_cmd & (rx_byte == OP_FLUSHR);

    // Next byte for MISO: status snapshot or read FIFO head, selected by byte index.
    always_comb begin
        tx_byte = 8'h00;
        if (in_cmd && op == OP_STATUS)
            tx_byte = stat_q[8*(3-idx) +: 8];
        else if (in_cmd && op == OP_READ && !rf_empty)
            tx_byte = rf_head[8*(3-idx) +: 8];
    end

    // Opcode decode, payload assembly and framing (R10, R11).
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            in_cmd <= 1'b0;
            op     <= OP_IDLE;
            idx    <= '0;
            pl     <= '0;
        end else if (rx_valid) begin
            if (!in_cmd) begin
                idx <= '0;
                op  <= opcode_t'(rx_byte);
                unique case (rx_byte)
                    OP_STATUS, OP_CONFIG, OP_ADDR, OP_RDLEN,
                    OP_WRITE, OP_READ, OP_TRST: in_cmd <= 1'b1;
                    default:                    in_cmd <= 1'b0;
                endcase
            end else begin
                idx <= idx + 2'd1;
                pl  <= word[23:0];
                if (idx == 2'd3 && op != OP_WRITE && op != OP_READ) in_cmd <= 1'b0;
            end
        end
    end

    // Status snapshot, config register and target reset pulse (R1, R2, R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q         <= '0;
            incr_q         <= 1'b1;
            ext_access_off <= 1'b0;
            tgt_reset      <= 1'b0;
        end else begin
            tgt_reset <= last & (op == OP_TRST);
            if (rx_valid && !in_cmd && rx_byte == OP_STATUS) stat_q <= status_now;
            if (last && op == OP_CONFIG) begin
                ext_access_off <= word[0];
                incr_q         <= word[1];
            end
        end
    end

    sbb_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .flush(wf_flush), .push(wf_push), .din(word),
        .pop(wf_pop), .dout(wf_head), .count(wf_count), .full(wf_full), .empty(wf_empty)
    );

    sbb_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .flush(rf_flush), .push(rf_push), .din(rf_din),
        .pop(rf_pop), .dout(rf_head), .count(rf_count), .full(rf_full), .empty(rf_empty)
    );

    sbb_bus_engine #(.AW(32), .DW(32), .LW(32)) u_engine (
        .clk(clk), .rst_n(rst_n), .incr(incr_q),
        .addr_load(addr_load), .addr_val(word),
        .len_load(len_load), .len_val(word), .flush_rd(rf_flush),
        .wf_empty(wf_empty), .wf_head(wf_head), .wf_pop(wf_pop),
        .rf_full(rf_full), .rf_push(rf_push), .rf_din(rf_din),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // R12: the target reset is a single-cycle pulse.
    p_trst_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |=> !tgt_reset);
    // R10: with chip select high the parser holds no open command.
    p_cs_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !in_cmd);
    // R7: a read-FIFO flush leaves it empty on the next cycle.
    p_flush_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_flush |=> rf_empty);
endmodule

// File: tb/tb_spi_bus_bridge.sv
module tb_spi_bus_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int DEPTH      = 8;
    localparam logic [31:0] ID_HI = 32'h5C00_0000;

    logic clk = 0, rst_n = 0;
    logic sclk = 0, cs_n = 1, mosi = 0, miso;
    logic bus_req, bus_we, bus_ack, ext_off, trst;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int checks = 0, fails = 0;
    logic hold = 0;
    logic [31:0] ram [64];
    int reads = 0, nops = 0, trst_cnt = 0;
    logic op_log [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bus_bridge #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .ext_access_off(ext_off), .tgt_reset(trst)
    );

    // Bus target model: 64-word RAM, one-cycle acknowledge unless held.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 0;
        end else begin
            bus_ack <= 0;
            if (bus_req && !bus_ack && !hold) begin
                bus_ack <= 1;
                if (bus_we) ram[bus_addr[7:2]] <= bus_wdata;
                else begin bus_rdata <= ram[bus_addr[7:2]]; reads <= reads + 1; end
                op_log[nops[7:0]] <= bus_we;
                nops <= nops + 1;
            end
            if (trst) trst_cnt <= trst_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        cs_n = 0; ticks(HALF);
    endtask

    task automatic cs_off();
        ticks(HALF); cs_n = 1; ticks(HALF);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            ticks(HALF);
            sclk = 1; r[i] = miso;
            ticks(HALF);
            sclk = 0;
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        logic [7:0] r;
        for (int k = 3; k >= 0; k--) xfer(w[8*k +: 8], r);
    endtask

    task automatic cmd32(input logic [7:0] op, input logic [31:0] v);
        logic [7:0] r;
        cs_on(); xfer(op, r); send_word(v); cs_off();
    endtask

    task automatic get_status(output logic [31:0] s);
        logic [7:0] r;
        cs_on(); xfer(8'h00, r);
        for (int k = 3; k >= 0; k--) xfer(8'h00, s[8*k +: 8]);
        cs_off();
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        cs_on(); xfer(op, r); cs_off();
    endtask

    task automatic wr_words(input int n, input logic [31:0] base);
        logic [7:0] r;
        cs_on(); xfer(8'h40, r);
        for (int i = 0; i < n; i++) send_word(base + 32'h0101_0101 * i);
        cs_off();
    endtask

    task automatic rd_check(input string tag, input int n, input int first);
        logic [7:0] r;
        logic [31:0] w;
        cs_on(); xfer(8'h50, r);
        for (int i = 0; i < n; i++) begin
            for (int k = 3; k >= 0; k--) xfer(8'h00, w[8*k +: 8]);
            chk(tag, w, ram[first + i]);
        end
        cs_off();
    endtask

    initial begin : main
        logic [31:0] s;
        int r0;
        for (int i = 0; i < 64; i++) ram[i] = 32'h0;
        ticks(4); rst_n = 1; ticks(4);

        // R1: reset state
        chk("R1 req", {31'b0, bus_req}, 0);
        chk("R1 lock", {31'b0, ext_off}, 0);
        get_status(s); chk("R1 status", s, ID_HI | 32'h0080_0000);

        // R2: config bits
        cmd32(8'h10, 32'h1); ticks(4);
        chk("R2 lock pin", {31'b0, ext_off}, 1);
        get_status(s); chk("R2 status", s, ID_HI | 32'h0040_0000);
        cmd32(8'h10, 32'h2); ticks(4);
        chk("R2 lock clear", {31'b0, ext_off}, 0);

        // R3: packing and increment
        cmd32(8'h20, 32'h10);
        wr_words(3, 32'h1122_3344); ticks(40);
        for (int i = 0; i < 3; i++) chk("R3 ram", ram[4 + i], 32'h1122_3344 + 32'h0101_0101 * i);

        // R4: no increment
        cmd32(8'h10, 32'h0); cmd32(8'h20, 32'h40);
        wr_words(2, 32'hDEAD_0001); ticks(40);
        chk("R4 same addr", ram[16], 32'hDEAD_0001 + 32'h0101_0101);
        chk("R4 next untouched", ram[17], 0);
        cmd32(8'h10, 32'h2);

        // R5: fetch N+1 words and stream out
        cmd32(8'h20, 32'h10); cmd32(8'h30, 32'd2); ticks(60);
        get_status(s); chk("R5 fill", s, ID_HI | 32'h0080_0000 | 32'd3);
        rd_check("R5 data", 3, 4);
        get_status(s); chk("R5 drained", s, ID_HI | 32'h0080_0000);

        // R6: stall when full, resume
        for (int i = 0; i < 12; i++) ram[8 + i] = 32'hC0DE_0000 + i;
        r0 = reads;
        cmd32(8'h20, 32'h20); cmd32(8'h30, 32'd11); ticks(100);
        get_status(s); chk("R6 stalled", s, ID_HI | 32'h0080_0000 | DEPTH);
        rd_check("R6 data a", 4, 8); ticks(60);
        get_status(s); chk("R6 refill", s, ID_HI | 32'h0080_0000 | DEPTH);
        rd_check("R6 data b", 8, 12); ticks(60);
        chk("R6 read total", reads - r0, 12);

        // R7: flush read FIFO cancels pending fetches
        cmd32(8'h20, 32'h20); cmd32(8'h30, 32'd11); ticks(100);
        op1(8'hFE); ticks(100);
        get_status(s); chk("R7 flushed", s, ID_HI | 32'h0080_0000);

        // R8: flush write FIFO, in-flight word completes
        hold = 1;
        cmd32(8'h20, 32'h60); wr_words(3, 32'hAB00_0000); ticks(10);
        get_status(s); chk("R8 queued", s, ID_HI | 32'h0080_0000 | (32'd2 << 11));
        op1(8'hFD);
        get_status(s); chk("R8 flushed", s, ID_HI | 32'h0080_0000);
        hold = 0; ticks(40);
        chk("R8 in flight", ram[24], 32'hAB00_0000);
        chk("R8 dropped", ram[25], 0);

        // R9: overflow drops words
        hold = 1;
        cmd32(8'h20, 32'h80); wr_words(10, 32'h7700_0000); ticks(10);
        get_status(s); chk("R9 full", s, ID_HI | 32'h0080_0000 | (DEPTH << 11));
        hold = 0; ticks(100);
        for (int i = 0; i < 9; i++) chk("R9 kept", ram[32 + i], 32'h7700_0000 + 32'h0101_0101 * i);
        chk("R9 lost", ram[41], 0);

        // R10: chip select abort of partial payload
        cmd32(8'h20, 32'hC0);
        begin
            logic [7:0] r;
            cs_on(); xfer(8'h20, r); xfer(8'h00, r); xfer(8'h00, r); cs_off();
        end
        wr_words(1, 32'h600D_F00D); ticks(40);
        chk("R10 abort", ram[48], 32'h600D_F00D);

        // R11: single-byte parser reset then status in same frame
        begin
            logic [7:0] r;
            cs_on(); xfer(8'hFF, r); xfer(8'h00, r);
            for (int k = 3; k >= 0; k--) xfer(8'h00, s[8*k +: 8]);
            cs_off();
        end
        chk("R11 status after FF", s, ID_HI | 32'h0080_0000);

        // R12: target reset pulse
        r0 = trst_cnt;
        cmd32(8'hFC, 32'h0); ticks(10);
        chk("R12 pulses", trst_cnt - r0, 1);

        // R13: writes before reads
        ram[58] = 32'h5A5A_5A5A;
        hold = 1;
        cmd32(8'h20, 32'hE0); wr_words(2, 32'h3300_0000);
        cmd32(8'h30, 32'd0);
        r0 = nops; hold = 0; ticks(60);
        chk("R13 order0", {31'b0, op_log[r0[7:0]]}, 1);
        chk("R13 order1", {31'b0, op_log[8'(r0 + 1)]}, 1);
        chk("R13 order2", {31'b0, op_log[8'(r0 + 2)]}, 0);
        rd_check("R13 read", 1, 58);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule